// File: doc/BRIEF.md
# Addressed Serial DAC Register Bank

This block is the digital front end of an eight-channel, 14-bit digital-to-analog converter. A host writes to it through a three-wire serial port made of a serial clock, a serial data line and a load line. While load is high, each rising serial clock edge shifts one bit into an 18-bit frame register. When load falls, the 14-bit code in the frame goes to the channel register named by the 4-bit address field. Only addresses 0 to 7 name a channel.

The serial pins run on their own timing and are not tied to the system clock. The block samples all three through two-flop synchronizers and finds serial clock edges by comparing the current synchronized sample with the one before it. A serial output carries the last stage of the frame register so that frames can be read back or passed down a chain of devices. It is driven only while load is high, and the block gives it as a data bit plus an output enable. An asynchronous preset forces every channel to the mid-scale code, which is zero volts in offset binary. Preset leaves the frame register alone.

A small control state machine sets the sequencing. ST_HOLD waits with shifting frozen and moves to ST_SHIFT when the synchronized load is high. ST_SHIFT accepts serial clock rising edges. When load falls it moves to ST_COMMIT if the synchronized serial clock is high, or to ST_FAULT if the clock is low. ST_COMMIT writes the addressed channel for one cycle. ST_FAULT raises the protocol-error pulse for one cycle. Both of these states return to ST_HOLD.

Top module: `sdac_bank`

## Requirements
- R1: A frame is 18 bits long. The first four bits shifted are the address, most significant bit first. The next fourteen are the channel code, most significant bit first. One bit is taken on each rising edge of ser_clk while ser_ld is high.
- R2: While ser_ld is low, edges and levels on ser_clk and ser_din have no effect, and the frame register keeps every bit.
- R3: When ser_ld falls with ser_clk high, the 14-bit code goes to channel A, where A is the address field. Addresses 0000 to 0111 select channels 0 to 7. Channel n is ch_code[14n+13:14n]. No other channel changes.
- R4: When the address field is 1000 to 1111, a falling ser_ld writes no channel.
- R5: ser_dout carries the last stage of the frame register, which is the earliest bit still held. After 18 shifts this is the address MSB, and each further shift brings out the next bit. ser_dout_oe is 1 while ser_ld is high and 0 while it is low.
- R6: rst_n low, or preset high, sets every channel to 0x2000 at once. Preset overrides a load that falls while preset is asserted.
- R7: Preset does not change the frame register. A frame shifted before a preset pulse is still written to its channel by a later load fall.
- R8: When ser_ld falls with ser_clk low, proto_err is high for exactly one system clock cycle and no channel is written.
- R9: Channel codes are offset binary and pass through unchanged, including 0x0000 (negative full scale) and 0x3FFF (one LSB below positive full scale).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset | input | 1 | Asynchronous active-high preset of all channels to mid-scale |
| ser_clk | input | 1 | Serial clock; the frame register shifts on its rising edge |
| ser_din | input | 1 | Serial data in |
| ser_ld | input | 1 | Load line: high to shift, falling edge to commit |
| ser_dout | output | 1 | Serial data out, the last frame register stage |
| ser_dout_oe | output | 1 | Output enable for ser_dout; low means high-impedance |
| proto_err | output | 1 | One-cycle pulse when load falls with the serial clock low |
| ch_code | output | 112 | Eight 14-bit channel codes; channel n at bits 14n+13:14n |

## Verification
The bench toggles the serial clock with the data line held at 1 while load is low. It then raises load and reads the output bit. A design that does not gate shifting would show the injected ones instead of the old address bit, and would commit a different code when load falls again. Frames with addresses 9 and 15 check that no channel is written on an out-of-range address, as an unmasked three-bit decode would write one. An extra shift after a full frame checks the chain output and the committed, shifted frame. A load drop with the clock low must produce a single error pulse and no write.

Preset is applied between shifting and commit to show that the frame survives. Preset is then held across a load fall to show that it wins. The bench also loads the extreme codes 0x0000 and 0x3FFF.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_FAULT  = 2'd3
    } sdac_state_e;

    function automatic logic [31:0] mid_scale(input int unsigned width);
        return 32'd1 << (width - 1);
    endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
    parameter int unsigned FRAME_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] frame_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        frame_q <= '0;
        else if (shift_en) frame_q <= {frame_q[FRAME_W-2:0], din};
    end

    AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(frame_q)); // R2
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
    import sdac_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_s,
    input  logic              clk_s,
    input  logic              clk_rise,
    input  logic [ADDR_W-1:0] addr,
    output logic              shift_en,
    output logic [NUM_CH-1:0] wr_en,
    output logic              proto_err
);
    sdac_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:   if (ld_s) state_d = ST_SHIFT;
            ST_SHIFT:  if (!ld_s) state_d = clk_s ? ST_COMMIT : ST_FAULT;
            ST_COMMIT: state_d = ST_HOLD;
            ST_FAULT:  state_d = ST_HOLD;
            default:   state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        shift_en  = 1'b0;
        proto_err = 1'b0;
        wr_en     = '0;
        unique case (state_q)
            ST_HOLD:   ;
            ST_SHIFT:  shift_en = ld_s && clk_rise;
            ST_COMMIT: begin
                for (int n = 0; n < NUM_CH; n++) begin
                    if (addr == ADDR_W'(n)) wr_en[n] = 1'b1;
                end
            end
            ST_FAULT:  proto_err = 1'b1;
            default:   ;
        endcase
    end

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en)); // R3
    AST_BAD_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && addr >= ADDR_W'(NUM_CH)) |-> (wr_en == '0)); // R4
    AST_FAULT_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> !$past(clk_s)); // R8
    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> (wr_en == '0)); // R8
endmodule

// File: rtl/sdac_chregs.sv
module sdac_chregs
    import sdac_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     preset,
    input  logic [NUM_CH-1:0]        wr_en,
    input  logic [DATA_W-1:0]        wdata,
    output logic [NUM_CH*DATA_W-1:0] ch_flat
);
    localparam logic [DATA_W-1:0] MID = DATA_W'(mid_scale(DATA_W));

    generate
        for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
            logic [DATA_W-1:0] code_q;
            always_ff @(posedge clk or negedge rst_n or posedge preset) begin
                if (!rst_n)         code_q <= MID;
                else if (preset)    code_q <= MID;
                else if (wr_en[n])  code_q <= wdata;
            end
            assign ch_flat[n*DATA_W +: DATA_W] = code_q;
        end
    endgenerate

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n || preset)
        (wr_en == '0) |=> $stable(ch_flat)); // R3
    AST_PRESET_MID: assert property (@(posedge clk) disable iff (!rst_n)
        preset |-> (ch_flat == {NUM_CH{MID}})); // R6
endmodule

// File: rtl/sdac_bank.sv
module sdac_bank #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 14,
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     preset,
    input  logic                     ser_clk,
    input  logic                     ser_din,
    input  logic                     ser_ld,
    output logic                     ser_dout,
    output logic                     ser_dout_oe,
    output logic                     proto_err,
    output logic [NUM_CH*DATA_W-1:0] ch_code
);
    localparam int unsigned FRAME_W = ADDR_W + DATA_W;

    logic [2:0]         pins_s;
    logic               clk_s, ld_s, din_s, clk_prev_q, clk_rise;
    logic               shift_en;
    logic [FRAME_W-1:0] frame_q;
    logic [NUM_CH-1:0]  wr_en;

    sdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_clk, ser_ld, ser_din}),
        .sync_out (pins_s)
    );
    assign {clk_s, ld_s, din_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev_q <= 1'b0;
        else        clk_prev_q <= clk_s;
    end
    assign clk_rise = clk_s && !clk_prev_q;

    sdac_ctrl #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_s      (ld_s),
        .clk_s     (clk_s),
        .clk_rise  (clk_rise),
        .addr      (frame_q[FRAME_W-1 -: ADDR_W]),
        .shift_en  (shift_en),
        .wr_en     (wr_en),
        .proto_err (proto_err)
    );

    sdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (din_s),
        .frame_q  (frame_q)
    );

    sdac_chregs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .preset  (preset),
        .wr_en   (wr_en),
        .wdata   (frame_q[DATA_W-1:0]),
        .ch_flat (ch_code)
    );

    assign ser_dout    = frame_q[FRAME_W-1];
    assign ser_dout_oe = ld_s;

    AST_SHIFT_ONLY_LD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> ser_dout_oe); // R2
    AST_OE_OFF_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_dout_oe |=> $stable(ser_dout)); // R5
endmodule

// File: tb/sdac_bank_tb.sv
module sdac_bank_tb;
    localparam int NCH = 8;
    localparam int DW  = 14;
    localparam int CW  = NCH * DW;
    localparam logic [DW-1:0] MID = 14'h2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic preset = 1'b0;
    logic ser_clk = 1'b1;
    logic ser_din = 1'b0;
    logic ser_ld = 1'b0;
    logic ser_dout, ser_dout_oe, proto_err;
    logic [CW-1:0] ch_code;

    always #10 clk = ~clk;

    sdac_bank u_dut (
        .clk(clk), .rst_n(rst_n), .preset(preset),
        .ser_clk(ser_clk), .ser_din(ser_din), .ser_ld(ser_ld),
        .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
        .proto_err(proto_err), .ch_code(ch_code)
    );

    int checks = 0;
    int errors = 0;
    int err_cycles = 0;
    bit done = 1'b0;

    typedef struct {
        logic [CW-1:0] exp;
        string         tag;
    } sb_item_t;
    sb_item_t sbq[$];

    logic [DW-1:0] model [NCH];

    function automatic logic [CW-1:0] pack_model();
        logic [CW-1:0] v;
        for (int n = 0; n < NCH; n++) v[n*DW +: DW] = model[n];
        return v;
    endfunction

    function automatic logic [17:0] mk(input logic [3:0] a, input logic [13:0] d);
        return {a, d};
    endfunction

    task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push_expect(input string tag);
        sb_item_t it;
        it.exp = pack_model();
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // Apply a frame to the reference model: address codes 0..7 write, others do nothing
    task automatic model_apply(input logic [17:0] f);
        if (f[17] == 1'b0) model[f[16:14]] = f[13:0];
    endtask

    task automatic model_preset();
        for (int n = 0; n < NCH; n++) model[n] = MID;
    endtask

    task automatic raise_ld();
        ser_ld = 1'b1;
        cyc(6);
    endtask

    task automatic shift_bits(input logic [17:0] f, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_din = f[i];
            ser_clk = 1'b0;
            cyc(4);
            ser_clk = 1'b1;
            cyc(4);
        end
    endtask

    task automatic drop_ld();
        ser_ld = 1'b0;
        cyc(8);
    endtask

    task automatic full_frame(input logic [17:0] f, input string tag);
        raise_ld();
        shift_bits(f, 18);
        drop_ld();
        model_apply(f);
        push_expect(tag);
        cyc(2);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            check(it.tag, ch_code, it.exp);
        end
        if (proto_err) err_cycles++;
    end

    initial begin
        logic [17:0] f, g;
        model_preset();
        cyc(5);
        rst_n = 1'b1;
        cyc(4);
        check("R6 reset mid-scale", ch_code, pack_model());
        check("R5 oe low at idle", CW'(ser_dout_oe), CW'(0));
        check("R8 no error at idle", CW'(proto_err), CW'(0));

        // R1 R3 R5: basic frame, dout after 18 shifts is address MSB
        f = mk(4'd3, 14'h1234);
        raise_ld();
        check("R5 oe high with load", CW'(ser_dout_oe), CW'(1));
        shift_bits(f, 18);
        check("R5 dout is address MSB", CW'(ser_dout), CW'(f[17]));
        drop_ld();
        check("R5 oe low after load", CW'(ser_dout_oe), CW'(0));
        model_apply(f);
        push_expect("R1 R3 channel 3 write");
        cyc(2);

        // R9: extreme codes
        full_frame(mk(4'd0, 14'h0000), "R9 channel 0 negative full scale");
        full_frame(mk(4'd7, 14'h3FFF), "R9 channel 7 top code");

        // R2: clock and data ignored while load low
        ser_din = 1'b1;
        for (int k = 0; k < 20; k++) begin
            ser_clk = 1'b0; cyc(4);
            ser_clk = 1'b1; cyc(4);
        end
        check("R2 oe stays low while gated", CW'(ser_dout_oe), CW'(0));
        raise_ld();
        check("R2 frame kept: dout", CW'(ser_dout), CW'(0));
        drop_ld();
        push_expect("R2 recommit of kept frame");
        cyc(2);

        // R4: out-of-range addresses write nothing
        full_frame(mk(4'd9, 14'h0555), "R4 address 9 ignored");
        full_frame(mk(4'd15, 14'h1111), "R4 address 15 ignored");

        // R5: one extra shift brings out next bit; committed frame is the shifted one
        f = mk(4'd11, 14'h2B3C);
        raise_ld();
        shift_bits(f, 18);
        check("R5 chain dout first", CW'(ser_dout), CW'(f[17]));
        shift_bits(18'd0, 1);
        check("R5 chain dout second", CW'(ser_dout), CW'(f[16]));
        drop_ld();
        g = {f[16:0], 1'b0};
        model_apply(g);
        push_expect("R5 shifted frame commit");
        cyc(2);

        // R8: load falls with serial clock low
        f = mk(4'd1, 14'h0F0F);
        raise_ld();
        shift_bits(f, 18);
        ser_clk = 1'b0;
        cyc(4);
        drop_ld();
        ser_clk = 1'b1;
        cyc(4);
        push_expect("R8 no write on fault");
        cyc(2);
        check("R8 single error pulse", CW'(err_cycles), CW'(1));

        // R7: preset between shift and commit keeps the frame
        f = mk(4'd5, 14'h1234);
        raise_ld();
        shift_bits(f, 18);
        preset = 1'b1;
        #2;
        model_preset();
        check("R6 preset async mid-scale", ch_code, pack_model());
        cyc(3);
        preset = 1'b0;
        cyc(2);
        drop_ld();
        model_apply(f);
        push_expect("R7 frame survives preset");
        cyc(2);

        // R6: preset overrides a load fall
        f = mk(4'd2, 14'h0AAA);
        raise_ld();
        shift_bits(f, 18);
        preset = 1'b1;
        cyc(1);
        model_preset();
        drop_ld();
        cyc(2);
        push_expect("R6 preset wins over load");
        cyc(2);
        preset = 1'b0;
        cyc(2);

        full_frame(mk(4'd6, 14'h2001), "R3 channel 6 after preset");
        check("R8 no further error pulses", CW'(err_cycles), CW'(1));

        cyc(4);
        check("R3 scoreboard drained", CW'(sbq.size()), CW'(0));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule